// File: doc/BRIEF.md
# Hot-Swap Bus Connect Controller

This block is the digital controller of a two-sided I2C/SMBus bus buffer placed between a plug-in card and a live backplane. It keeps the card's SDA/SCL pair isolated from the backplane pair while the card powers up. During that time it requests precharge of the card-side pins. It joins the two pairs only when the bus is quiet. Once joined, it repeats lows in both directions, acting as a digital open-drain repeater.

The controller is a four-state machine:

- `ST_OFF` is the disconnected, low-power state.
- `ST_INIT` is the fixed-length initialization period, with precharge requested.
- `ST_WAIT` is the armed state, still precharging, in which a quiet-bus detector watches all four lines.
- `ST_LINK` is the joined state.

The transitions are:

- Any state goes to `ST_OFF` whenever the supply-good flag or the enable input is low.
- `ST_OFF` goes to `ST_INIT` when both are high.
- `ST_INIT` goes to `ST_WAIT` after `INIT_CYCLES` cycles.
- `ST_WAIT` goes to `ST_LINK` on a join request. A join request is either a bus-idle timeout or a STOP seen on the card pair while all lines are high.

Each of the SDA and SCL pairs has its own repeater. The repeater has four states:

- `RP_IDLE`: nothing is driven.
- `RP_CARD`: the card side originated a low, so the backplane line is pulled.
- `RP_BP`: the backplane side originated a low, so the card line is pulled.
- `RP_HOLD`: a short window after a release, in which both synchronized inputs are ignored so that the block never latches onto the low it was itself driving.

The repeater transitions are:

- `RP_IDLE` goes to `RP_CARD` on a card low, or to `RP_BP` on a backplane low. The card side wins when both are low together.
- `RP_CARD` and `RP_BP` go to `RP_HOLD` when the originating side goes high.
- `RP_HOLD` goes back to `RP_IDLE` after `SYNC_DEPTH+1` cycles.
- Any repeater state goes to `RP_IDLE` when the controller is not in `ST_LINK`.

All four line inputs pass through two-flop synchronizers. Line inputs are active high: 1 means the wire is high. Pull-down outputs are active high: 1 means pull the wire low.

Top module: `hotswap_link_ctrl`

## Requirements
- R1: While `supply_ok` is low, one clock later `linked`, `precharge_en` and all four pull-down outputs are 0, whatever the line levels are.
- R2: A low on `enable` in any state makes `linked`, `precharge_en` and all pull-downs 0 one clock later.
- R3: When `supply_ok` and `enable` are both high in `ST_OFF`, `precharge_en` rises one clock later. It stays high through `INIT_CYCLES` cycles of initialization and the whole wait period. It falls in the same cycle that `linked` rises.
- R4: A STOP or quiet bus occurring during initialization does not connect. The idle count starts only when `ST_WAIT` is entered.
- R5: In `ST_WAIT`, the block connects once all four synchronized lines have been high for `IDLE_CYCLES` consecutive cycles. Any line seen low restarts the count. A raw release that completes the quiet period connects `IDLE_CYCLES+2` clocks after the release.
- R6: In `ST_WAIT`, a rising card SDA while card SCL and both backplane lines are high connects 3 clocks after the raw edge. A rising card SDA while card SCL is low does not connect.
- R7: While linked, a low on one line of a pair asserts the pull-down on the other line of that pair 3 clocks after the raw low. SDA and SCL are independent, and the two pull-downs of one pair are never both asserted.
- R8: The pull-down is released 3 clocks after the originating side goes high. The low the block itself was driving never causes a pull-down back onto the originating side.
- R9: If the far side is still held low by an external driver after the originator releases, the direction swaps. The originator's line is pulled low 7 clocks after its release and stays pulled until 3 clocks after that external driver releases.
- R10: When both lines of a pair fall in the same cycle, the card side is treated as the originator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply-good flag, synchronous |
| enable | input | 1 | Enable, synchronous; low forces disconnect |
| card_sda_i | input | 1 | Card-side SDA level |
| card_scl_i | input | 1 | Card-side SCL level |
| bp_sda_i | input | 1 | Backplane-side SDA level |
| bp_scl_i | input | 1 | Backplane-side SCL level |
| card_sda_pd | output | 1 | Pull card SDA low |
| card_scl_pd | output | 1 | Pull card SCL low |
| bp_sda_pd | output | 1 | Pull backplane SDA low |
| bp_scl_pd | output | 1 | Pull backplane SCL low |
| precharge_en | output | 1 | Request precharge of the card-side pins |
| linked | output | 1 | Pairs are joined |

## Verification
The control inputs act after one clock edge. A raw line change reaches the repeater and quiet detector after three edges: two synchronizer stages and one state register. A STOP therefore connects three edges after the raw SDA rise, and an idle release connects `IDLE_CYCLES+2` edges later. The bench drives every input at a falling edge, counts rising edges from that point, and samples at the following falling edge. It sweeps every cycle of the power-up window and every pair, side and pulse length, comparing each cycle against an expected value computed from these delays. The bench models the wires as wired-AND of its external drivers and the block's pull-downs, so release and direction-swap timing includes the block's own feedback.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
    typedef enum logic [1:0] {ST_OFF, ST_INIT, ST_WAIT, ST_LINK} link_state_t;
    typedef enum logic [1:0] {RP_IDLE, RP_CARD, RP_BP, RP_HOLD} rep_state_t;
    localparam int SYNC_DEPTH = 2;
    localparam int NUM_LINES  = 4;
    // line vector order: [0] card SDA, [1] card SCL, [2] bp SDA, [3] bp SCL
    localparam int L_CSDA = 0;
    localparam int L_CSCL = 1;
    localparam int L_BSDA = 2;
    localparam int L_BSCL = 3;
endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
    parameter int W     = 4,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '1;
                else        stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '1;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/hsw_quiet_det.sv
module hsw_quiet_det
    import hsw_pkg::*;
#(
    parameter int IDLE_CYCLES = 500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 armed,
    input  logic [NUM_LINES-1:0] lines,
    output logic                 join_req
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

    logic [CW-1:0] idle_cnt;
    logic          sda_prev;
    logic          all_hi;
    logic          stop_hit;
    logic          idle_hit;

    assign all_hi   = &lines;
    assign stop_hit = armed && all_hi && !sda_prev;
    assign idle_hit = armed && all_hi && (idle_cnt == LAST);
    assign join_req = stop_hit || idle_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            sda_prev <= 1'b1;
        end else begin
            sda_prev <= lines[L_CSDA];
            if (!armed || !all_hi)   idle_cnt <= '0;
            else if (idle_cnt != LAST) idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hsw_pair_rep.sv
module hsw_pair_rep
    import hsw_pkg::*;
#(
    parameter int HOLD = SYNC_DEPTH + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic card_low,
    input  logic bp_low,
    output logic drive_card,
    output logic drive_bp
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD - 1);

    rep_state_t    st_q, st_d;
    logic [HW-1:0] hold_cnt;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d = RP_IDLE;
        end else begin
            unique case (st_q)
                RP_IDLE: begin
                    if (card_low)    st_d = RP_CARD;
                    else if (bp_low) st_d = RP_BP;
                end
                RP_CARD: if (!card_low) st_d = RP_HOLD;
                RP_BP:   if (!bp_low)   st_d = RP_HOLD;
                RP_HOLD: if (hold_cnt == HOLD_LAST) st_d = RP_IDLE;
                default: st_d = RP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= RP_IDLE;
            hold_cnt <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == RP_HOLD && st_d == RP_HOLD) hold_cnt <= hold_cnt + 1'b1;
            else                                    hold_cnt <= '0;
        end
    end

    always_comb begin
        drive_card = (st_q == RP_BP);
        drive_bp   = (st_q == RP_CARD);
    end
endmodule

// File: rtl/hotswap_link_ctrl.sv
module hotswap_link_ctrl
    import hsw_pkg::*;
#(
    parameter int INIT_CYCLES = 1000,
    parameter int IDLE_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic enable,
    input  logic card_sda_i,
    input  logic card_scl_i,
    input  logic bp_sda_i,
    input  logic bp_scl_i,
    output logic card_sda_pd,
    output logic card_scl_pd,
    output logic bp_sda_pd,
    output logic bp_scl_pd,
    output logic precharge_en,
    output logic linked
);
    localparam int IW = $clog2(INIT_CYCLES + 1);
    localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYCLES - 1);
    localparam int NPAIR = 2;

    link_state_t          state_q, state_d;
    logic [IW-1:0]        init_cnt;
    logic [NUM_LINES-1:0] raw_lines, sync_lines;
    logic                 join_req;
    logic                 power_on;
    logic [NPAIR-1:0]     drv_card, drv_bp;

    assign raw_lines = {bp_scl_i, bp_sda_i, card_scl_i, card_sda_i};
    assign power_on  = supply_ok && enable;

    hsw_sync #(.W(NUM_LINES), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
    );

    hsw_quiet_det #(.IDLE_CYCLES(IDLE_CYCLES)) u_quiet (
        .clk(clk), .rst_n(rst_n), .armed(state_q == ST_WAIT),
        .lines(sync_lines), .join_req(join_req)
    );

    // pair 0 = SDA, pair 1 = SCL
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        hsw_pair_rep u_rep (
            .clk       (clk),
            .rst_n     (rst_n),
            .active    (state_q == ST_LINK),
            .card_low  (!sync_lines[p]),
            .bp_low    (!sync_lines[p+2]),
            .drive_card(drv_card[p]),
            .drive_bp  (drv_bp[p])
        );
    end

    always_comb begin
        state_d = state_q;
        if (!power_on) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_INIT;
                ST_INIT: if (init_cnt == INIT_LAST) state_d = ST_WAIT;
                ST_WAIT: if (join_req) state_d = ST_LINK;
                ST_LINK: state_d = ST_LINK;
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_OFF;
            init_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INIT && state_d == ST_INIT) init_cnt <= init_cnt + 1'b1;
            else                                          init_cnt <= '0;
        end
    end

    always_comb begin
        linked       = (state_q == ST_LINK);
        precharge_en = (state_q == ST_INIT) || (state_q == ST_WAIT);
        card_sda_pd  = linked && drv_card[0];
        card_scl_pd  = linked && drv_card[1];
        bp_sda_pd    = linked && drv_bp[0];
        bp_scl_pd    = linked && drv_bp[1];
    end
endmodule

// File: rtl/hsw_link_chk.sv
module hsw_link_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic enable,
    input logic card_sda_pd,
    input logic card_scl_pd,
    input logic bp_sda_pd,
    input logic bp_scl_pd,
    input logic precharge_en,
    input logic linked
);
    // R1
    supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!linked && !precharge_en && !card_sda_pd && !card_scl_pd
                        && !bp_sda_pd && !bp_scl_pd));

    // R2
    enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!linked && !precharge_en));

    // R3
    link_after_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(linked) |-> $past(precharge_en));

    // R7
    sda_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_sda_pd && bp_sda_pd));

    // R7
    scl_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_scl_pd && bp_scl_pd));

    // R7
    pd_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_sda_pd || card_scl_pd || bp_sda_pd || bp_scl_pd) |-> linked);

    // R8
    no_bounce_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bp_sda_pd) |=> !card_sda_pd);
endmodule

bind hotswap_link_ctrl hsw_link_chk u_chk (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
    .card_sda_pd(card_sda_pd), .card_scl_pd(card_scl_pd),
    .bp_sda_pd(bp_sda_pd), .bp_scl_pd(bp_scl_pd),
    .precharge_en(precharge_en), .linked(linked)
);

// File: tb/tb_hotswap_link_ctrl.sv
module tb_hotswap_link_ctrl;
    localparam int INIT = 4;
    localparam int IDLE = 20;

    logic clk = 1'b0;
    logic rst_n, supply_ok, enable;
    logic c_sda_x, c_scl_x, b_sda_x, b_scl_x;
    logic card_sda_i, card_scl_i, bp_sda_i, bp_scl_i;
    logic card_sda_pd, card_scl_pd, bp_sda_pd, bp_scl_pd, precharge_en, linked;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    always #5 clk = ~clk;

    assign card_sda_i = c_sda_x & ~card_sda_pd;
    assign card_scl_i = c_scl_x & ~card_scl_pd;
    assign bp_sda_i   = b_sda_x & ~bp_sda_pd;
    assign bp_scl_i   = b_scl_x & ~bp_scl_pd;

    hotswap_link_ctrl #(.INIT_CYCLES(INIT), .IDLE_CYCLES(IDLE)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
        .card_sda_i(card_sda_i), .card_scl_i(card_scl_i),
        .bp_sda_i(bp_sda_i), .bp_scl_i(bp_scl_i),
        .card_sda_pd(card_sda_pd), .card_scl_pd(card_scl_pd),
        .bp_sda_pd(bp_sda_pd), .bp_scl_pd(bp_scl_pd),
        .precharge_en(precharge_en), .linked(linked)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet_outs(input string tag);
        chk({tag, " linked"}, linked, 1'b0);
        chk({tag, " precharge"}, precharge_en, 1'b0);
        chk({tag, " pulldowns"}, card_sda_pd | card_scl_pd | bp_sda_pd | bp_scl_pd, 1'b0);
    endtask

    // p: 0 SDA, 1 SCL; s: 0 card, 1 backplane
    task automatic set_ext(input int p, input int s, input logic v);
        if (p == 0 && s == 0) c_sda_x = v;
        if (p == 1 && s == 0) c_scl_x = v;
        if (p == 0 && s == 1) b_sda_x = v;
        if (p == 1 && s == 1) b_scl_x = v;
    endtask

    function automatic logic pd_of(input int p, input int s);
        if (p == 0) return (s == 0) ? card_sda_pd : bp_sda_pd;
        return (s == 0) ? card_scl_pd : bp_scl_pd;
    endfunction

    task automatic power_up_to_link();
        enable = 1'b1; supply_ok = 1'b1;
        step(INIT + IDLE + 1);
        chk("R3 R5 link reached", linked, 1'b1);
    endtask

    task automatic power_down();
        enable = 1'b0;
        step(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; supply_ok = 1'b0; enable = 1'b0;
        c_sda_x = 1'b1; c_scl_x = 1'b1; b_sda_x = 1'b1; b_scl_x = 1'b1;
        step(3);
        quiet_outs("R1 reset");
        rst_n = 1'b1;
        step(1);

        // R1: enable high but supply not good, lines busy
        enable = 1'b1; c_sda_x = 1'b0; b_scl_x = 1'b0;
        for (int k = 0; k < 10; k++) begin
            step(1);
            quiet_outs("R1 no supply");
        end
        c_sda_x = 1'b1; b_scl_x = 1'b1;
        enable = 1'b0;
        step(4);

        // R3/R5 sweep over the whole power-up window
        supply_ok = 1'b1; enable = 1'b1;
        for (int n = 1; n <= INIT + IDLE + 3; n++) begin
            step(1);
            chk("R3 precharge window", precharge_en, logic'(n <= INIT + IDLE));
            chk("R5 idle link time", linked, logic'(n >= INIT + IDLE + 1));
        end

        // R7/R8 sweep: every pair, side, low length
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 2; s++) begin
                for (int len = 1; len <= 4; len++) begin
                    set_ext(p, s, 1'b0);
                    for (int k = 1; k <= len + 10; k++) begin
                        if (k == len + 1) set_ext(p, s, 1'b1);
                        @(posedge clk); @(negedge clk);
                        if (k == len) set_ext(p, s, 1'b1);
                        chk("R7 far pulldown", pd_of(p, 1 - s), logic'(k >= 3 && k < len + 3));
                        chk("R8 no bounce back", pd_of(p, s), 1'b0);
                        chk("R7 other pair idle", pd_of(1 - p, 0) | pd_of(1 - p, 1), 1'b0);
                    end
                end
            end
        end

        // R10: simultaneous lows on SDA, card wins
        c_sda_x = 1'b0; b_sda_x = 1'b0;
        step(3);
        chk("R10 card wins bp pd", bp_sda_pd, 1'b1);
        chk("R10 card wins card pd", card_sda_pd, 1'b0);
        // R9: card releases while backplane still held low
        c_sda_x = 1'b1;
        step(3);
        chk("R9 originator released", bp_sda_pd, 1'b0);
        step(3);
        chk("R9 hold window", card_sda_pd, 1'b0);
        step(1);
        chk("R9 direction swap", card_sda_pd, 1'b1);
        step(5);
        chk("R9 held while far low", card_sda_pd, 1'b1);
        b_sda_x = 1'b1;
        step(2);
        chk("R9 not yet released", card_sda_pd, 1'b1);
        step(1);
        chk("R9 released", card_sda_pd, 1'b0);
        for (int k = 0; k < 8; k++) begin
            step(1);
            chk("R8 settled sda", card_sda_pd | bp_sda_pd, 1'b0);
        end

        // R2: enable low while repeating a low
        c_scl_x = 1'b0;
        step(3);
        chk("R7 scl repeat", bp_scl_pd, 1'b1);
        enable = 1'b0;
        step(1);
        quiet_outs("R2 enable low");
        c_scl_x = 1'b1;
        step(4);

        // R4: STOP during init ignored; idle starts at wait
        c_sda_x = 1'b0; enable = 1'b1;
        step(1);
        c_sda_x = 1'b1;
        step(INIT + IDLE - 1);
        chk("R4 no early link", linked, 1'b0);
        step(1);
        chk("R4 link after full idle", linked, 1'b1);

        // R6: STOP in wait connects after 3 edges
        power_down();
        c_sda_x = 1'b0; enable = 1'b1;
        step(INIT + 4);
        chk("R6 waiting", precharge_en, 1'b1);
        c_sda_x = 1'b1;
        step(2);
        chk("R6 not yet", linked, 1'b0);
        step(1);
        chk("R6 stop link", linked, 1'b1);
        chk("R3 precharge off at link", precharge_en, 1'b0);

        // R6 negative and R5 restart: SDA rises while SCL low
        power_down();
        c_sda_x = 1'b0; c_scl_x = 1'b0; enable = 1'b1;
        step(INIT + 4);
        c_sda_x = 1'b1;
        step(3);
        chk("R6 scl low no link", linked, 1'b0);
        c_scl_x = 1'b1;
        step(IDLE + 1);
        chk("R5 restart not yet", linked, 1'b0);
        step(1);
        chk("R5 restart link", linked, 1'b1);

        // R1: supply drop while linked and driving
        b_sda_x = 1'b0;
        step(3);
        chk("R7 bp origin", card_sda_pd, 1'b1);
        supply_ok = 1'b0;
        step(1);
        quiet_outs("R1 supply drop");
        b_sda_x = 1'b1;
        step(2);
        power_up_to_link();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule